// File: doc/BRIEF.md
# Data Eye Centering Trainer

This block trains the per-bit capture and launch delays of a double-data-rate memory data path. For every data bit it sweeps a delay tap over its full range, notes the lowest and the highest tap at which the returned data matches a known training pattern, and then sets that bit's tap to the middle of the passing range. Every bit keeps its own window. The sweep is done in parallel across bits, but the windows are recorded separately.

Training runs in two phases, and the read phase always comes first. For the read phase, the block sets the pattern-readback bit in the memory's mode register. It loads the training pattern into the memory's pattern register with one write, and then sweeps the read taps using reads that return that stored pattern. It then clears the pattern-readback bit, which restores normal array reads. For the write phase, it sweeps the write taps with a loop that writes the pattern to the array and reads it back, while the trained read taps stay fixed. A bit that never passes gets tap 0 and a sticky error flag. Training still finishes and signals completion.

The surrounding controller pulses `start` and waits for `done`. The mode-register port and the command port are one-cycle strobes that the memory side accepts without back-pressure. Read data comes back as one wide word carrying all beats, marked by `rd_valid`.

Top module: `eye_center_trainer`

## Requirements
- R1: After reset, `busy`, `done`, `cmd_valid`, `mrw_valid` and `bit_err` are all 0, and every read and write tap is 0.
- R2: After an accepted `start`, the first action is a mode-register write to register 3 with data bit 2 set (pattern readback on). The first command after that is exactly one WRITE, which loads the pattern register. No READ comes before that WRITE, and `cmd_valid` and `mrw_valid` are never high together.
- R3: Every WRITE carries the training pattern. Beat k occupies `cmd_wdata[k*DQ_W +: DQ_W]`, with 8 beats. Every byte of an even beat is 0x55 and every byte of an odd beat is 0xAA.
- R4: The read sweep issues exactly 2^TAP_W READs in pattern-readback mode. For the n-th READ (n counted from 0), every read tap equals n. No write-phase command is issued before this sweep ends.
- R5: After the read sweep, and before any array WRITE, a mode-register write to register 3 clears data bit 2. Exactly two mode-register writes occur per training run.
- R6: Each bit's final read tap is floor((lo+hi)/2), where lo and hi are the lowest and the highest passing tap of that bit in the read sweep. A tap passes when all 8 beats of that bit match the pattern.
- R7: The write sweep issues 2^TAP_W pairs of a WRITE followed by a READ. For the n-th WRITE, every write tap equals n. During the whole write sweep, every read tap holds its trained value.
- R8: Each bit's final write tap is floor((lo+hi)/2) of its passing taps in the write sweep.
- R9: A bit with no passing tap in a phase gets tap 0 for that phase, and its `bit_err` flag is set. The flag stays set until the next accepted `start`, which clears all flags. `done` is asserted regardless.
- R10: `busy` rises the cycle after an accepted `start` and is never high together with `done`. `done` rises when training ends and stays high until the next accepted `start`.
- R11: A `start` pulse while `busy` is high is ignored. The run continues with no extra mode-register writes or commands, and it ends with the same results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a training run (accepted when idle) |
| busy | output | 1 | Training in progress |
| done | output | 1 | Training finished; held until next start |
| mrw_valid | output | 1 | Mode-register write strobe |
| mrw_reg | output | MR_AW | Mode-register index |
| mrw_data | output | MR_W | Mode-register write value |
| cmd_valid | output | 1 | Command strobe |
| cmd_wr | output | 1 | 1 = WRITE, 0 = READ |
| cmd_wdata | output | BEATS*DQ_W | Write data, all beats |
| rd_valid | input | 1 | Returned read data valid (one cycle) |
| rd_data | input | BEATS*DQ_W | Returned read data, all beats |
| rd_tap | output | DQ_W*TAP_W | Per-bit read delay taps, bit b at [b*TAP_W +: TAP_W] |
| wr_tap | output | DQ_W*TAP_W | Per-bit write delay taps, bit b at [b*TAP_W +: TAP_W] |
| bit_err | output | DQ_W | Sticky per-bit training failure flags |

## Verification
The bench builds the block with DQ_W=16, which gives two byte lanes, and with the default TAP_W=6, so every sweep covers all 64 taps. This makes the edge windows reachable: a window that is only tap 0, one that is only tap 63, a two-tap window at the top, the full range, and empty windows in either phase. A behavioural memory model forces a bit to 0 whenever its tap falls outside a per-bit window. It also returns reads after a random delay, which tests the wait logic.

// File: rtl/eye_train_pkg.sv
`timescale 1ns/1ps
package eye_train_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_MR_ON,
    ST_LOAD,
    ST_R_SET,
    ST_R_CMD,
    ST_R_WAIT,
    ST_R_FIN,
    ST_MR_OFF,
    ST_W_SET,
    ST_W_WR,
    ST_W_RD,
    ST_W_WAIT,
    ST_W_FIN
  } train_st_e;

  // Training pattern bit: even beats carry 0x55 per byte, odd beats 0xAA.
  function automatic logic pat_bit(input int unsigned beat, input int unsigned bitn);
    return ((beat % 2) == (bitn % 2));
  endfunction

endpackage

// File: rtl/eye_pattern_src.sv
`timescale 1ns/1ps
module eye_pattern_src
  import eye_train_pkg::*;
#(
  parameter int DQ_W  = 16,
  parameter int BEATS = 8
) (
  output logic [BEATS*DQ_W-1:0] pat
);

  for (genvar k = 0; k < BEATS; k++) begin : g_beat
    for (genvar b = 0; b < DQ_W; b++) begin : g_bit
      assign pat[k*DQ_W + b] = pat_bit(k, b);
    end
  end

endmodule

// File: rtl/eye_bit_check.sv
`timescale 1ns/1ps
module eye_bit_check #(
  parameter int DQ_W  = 16,
  parameter int BEATS = 8
) (
  input  logic [BEATS*DQ_W-1:0] got,
  input  logic [BEATS*DQ_W-1:0] want,
  output logic [DQ_W-1:0]       pass
);

  for (genvar b = 0; b < DQ_W; b++) begin : g_bit
    logic [BEATS-1:0] diff;
    for (genvar k = 0; k < BEATS; k++) begin : g_beat
      assign diff[k] = got[k*DQ_W + b] ^ want[k*DQ_W + b];
    end
    assign pass[b] = ~|diff;
  end

endmodule

// File: rtl/eye_bit_window.sv
`timescale 1ns/1ps
module eye_bit_window #(
  parameter int TAP_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             smp,
  input  logic             pass,
  input  logic [TAP_W-1:0] tap,
  output logic [TAP_W-1:0] mid,
  output logic             fail
);

  logic             found_q;
  logic [TAP_W-1:0] lo_q;
  logic [TAP_W-1:0] hi_q;
  logic [TAP_W:0]   sum;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      found_q <= 1'b0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else if (smp && pass) begin
      if (!found_q) begin
        lo_q    <= tap;
        found_q <= 1'b1;
      end
      hi_q <= tap;
    end
  end

  assign sum  = {1'b0, lo_q} + {1'b0, hi_q};
  assign mid  = sum[TAP_W:1];
  assign fail = ~found_q;

  // R6: the recorded window never inverts
  assert_window_order_R6: assert property (@(posedge clk) disable iff (rst)
    found_q |-> (hi_q >= lo_q));

endmodule

// File: rtl/eye_train_fsm.sv
`timescale 1ns/1ps
module eye_train_fsm
  import eye_train_pkg::*;
#(
  parameter int               TAP_W   = 6,
  parameter int               MR_AW   = 3,
  parameter int               MR_W    = 16,
  parameter int               MR_SEL  = 3,
  parameter int               MPR_BIT = 2,
  parameter logic [MR_W-1:0]  MR_BASE = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             rd_valid,
  output logic             busy,
  output logic             done,
  output logic             mrw_valid,
  output logic [MR_AW-1:0] mrw_reg,
  output logic [MR_W-1:0]  mrw_data,
  output logic             cmd_valid,
  output logic             cmd_wr,
  output logic [TAP_W-1:0] scan_tap,
  output logic             load_rd_scan,
  output logic             load_wr_scan,
  output logic             commit_rd,
  output logic             commit_wr,
  output logic             trk_clr,
  output logic             trk_smp,
  output logic             err_clr
);

  localparam logic [TAP_W-1:0] TAP_MAX    = {TAP_W{1'b1}};
  localparam logic [MR_W-1:0]  MPR_MASK   = MR_W'(1) << MPR_BIT;
  localparam logic [MR_W-1:0]  MR_ON_VAL  = MR_BASE | MPR_MASK;
  localparam logic [MR_W-1:0]  MR_OFF_VAL = MR_BASE & ~MPR_MASK;

  train_st_e        state;
  logic [TAP_W-1:0] scan_q;
  logic             busy_q, done_q, mrw_v_q, cmd_v_q, cmd_w_q;
  logic [MR_W-1:0]  mrw_d_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      scan_q  <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      mrw_v_q <= 1'b0;
      mrw_d_q <= '0;
      cmd_v_q <= 1'b0;
      cmd_w_q <= 1'b0;
    end else begin
      mrw_v_q <= 1'b0;
      cmd_v_q <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state  <= ST_MR_ON;
          busy_q <= 1'b1;
          done_q <= 1'b0;
        end
        ST_MR_ON: begin
          mrw_v_q <= 1'b1;
          mrw_d_q <= MR_ON_VAL;
          state   <= ST_LOAD;
        end
        ST_LOAD: begin
          cmd_v_q <= 1'b1;
          cmd_w_q <= 1'b1;
          scan_q  <= '0;
          state   <= ST_R_SET;
        end
        ST_R_SET: state <= ST_R_CMD;
        ST_R_CMD: begin
          cmd_v_q <= 1'b1;
          cmd_w_q <= 1'b0;
          state   <= ST_R_WAIT;
        end
        ST_R_WAIT: if (rd_valid) begin
          if (scan_q == TAP_MAX) state <= ST_R_FIN;
          else begin
            scan_q <= scan_q + 1'b1;
            state  <= ST_R_SET;
          end
        end
        ST_R_FIN: state <= ST_MR_OFF;
        ST_MR_OFF: begin
          mrw_v_q <= 1'b1;
          mrw_d_q <= MR_OFF_VAL;
          scan_q  <= '0;
          state   <= ST_W_SET;
        end
        ST_W_SET: state <= ST_W_WR;
        ST_W_WR: begin
          cmd_v_q <= 1'b1;
          cmd_w_q <= 1'b1;
          state   <= ST_W_RD;
        end
        ST_W_RD: begin
          cmd_v_q <= 1'b1;
          cmd_w_q <= 1'b0;
          state   <= ST_W_WAIT;
        end
        ST_W_WAIT: if (rd_valid) begin
          if (scan_q == TAP_MAX) state <= ST_W_FIN;
          else begin
            scan_q <= scan_q + 1'b1;
            state  <= ST_W_SET;
          end
        end
        ST_W_FIN: begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy         = busy_q;
  assign done         = done_q;
  assign mrw_valid    = mrw_v_q;
  assign mrw_reg      = MR_AW'(MR_SEL);
  assign mrw_data     = mrw_d_q;
  assign cmd_valid    = cmd_v_q;
  assign cmd_wr       = cmd_w_q;
  assign scan_tap     = scan_q;
  assign load_rd_scan = (state == ST_R_SET);
  assign load_wr_scan = (state == ST_W_SET);
  assign commit_rd    = (state == ST_R_FIN);
  assign commit_wr    = (state == ST_W_FIN);
  assign err_clr      = (state == ST_IDLE) && start;
  assign trk_clr      = err_clr || (state == ST_MR_OFF);
  assign trk_smp      = ((state == ST_R_WAIT) || (state == ST_W_WAIT)) && rd_valid;

  // R2: mode-register writes and commands never overlap
  assert_cmd_mrw_excl_R2: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && mrw_valid));

  // R4: a command seen while awaiting read-sweep data is a READ
  assert_read_only_sweep_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && state == ST_R_WAIT) |-> !cmd_wr);

  // R11: a start pulse mid-run does not end the run
  assert_start_ignored_R11: assert property (@(posedge clk) disable iff (rst)
    (busy && start && state != ST_W_FIN) |=> busy);

endmodule

// File: rtl/eye_center_trainer.sv
`timescale 1ns/1ps
module eye_center_trainer #(
  parameter int              DQ_W    = 16,
  parameter int              TAP_W   = 6,
  parameter int              BEATS   = 8,
  parameter int              MR_AW   = 3,
  parameter int              MR_W    = 16,
  parameter int              MR_SEL  = 3,
  parameter int              MPR_BIT = 2,
  parameter logic [MR_W-1:0] MR_BASE = '0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  output logic                    busy,
  output logic                    done,
  output logic                    mrw_valid,
  output logic [MR_AW-1:0]        mrw_reg,
  output logic [MR_W-1:0]         mrw_data,
  output logic                    cmd_valid,
  output logic                    cmd_wr,
  output logic [BEATS*DQ_W-1:0]   cmd_wdata,
  input  logic                    rd_valid,
  input  logic [BEATS*DQ_W-1:0]   rd_data,
  output logic [DQ_W*TAP_W-1:0]   rd_tap,
  output logic [DQ_W*TAP_W-1:0]   wr_tap,
  output logic [DQ_W-1:0]         bit_err
);

  localparam int BUS_W = BEATS * DQ_W;

  logic [TAP_W-1:0] scan_tap;
  logic             load_rd_scan, load_wr_scan, commit_rd, commit_wr;
  logic             trk_clr, trk_smp, err_clr;
  logic [BUS_W-1:0] pat;
  logic [DQ_W-1:0]  pass, fail;
  logic [TAP_W-1:0] mid [DQ_W];
  logic [TAP_W-1:0] rd_tap_q [DQ_W];
  logic [TAP_W-1:0] wr_tap_q [DQ_W];
  logic [DQ_W-1:0]  err_q;

  eye_train_fsm #(
    .TAP_W(TAP_W), .MR_AW(MR_AW), .MR_W(MR_W),
    .MR_SEL(MR_SEL), .MPR_BIT(MPR_BIT), .MR_BASE(MR_BASE)
  ) u_fsm (
    .clk(clk), .rst(rst), .start(start), .rd_valid(rd_valid),
    .busy(busy), .done(done),
    .mrw_valid(mrw_valid), .mrw_reg(mrw_reg), .mrw_data(mrw_data),
    .cmd_valid(cmd_valid), .cmd_wr(cmd_wr),
    .scan_tap(scan_tap),
    .load_rd_scan(load_rd_scan), .load_wr_scan(load_wr_scan),
    .commit_rd(commit_rd), .commit_wr(commit_wr),
    .trk_clr(trk_clr), .trk_smp(trk_smp), .err_clr(err_clr)
  );

  eye_pattern_src #(.DQ_W(DQ_W), .BEATS(BEATS)) u_pat (.pat(pat));

  eye_bit_check #(.DQ_W(DQ_W), .BEATS(BEATS)) u_chk (
    .got(rd_data), .want(pat), .pass(pass)
  );

  assign cmd_wdata = pat;

  for (genvar b = 0; b < DQ_W; b++) begin : g_lane
    eye_bit_window #(.TAP_W(TAP_W)) u_win (
      .clk(clk), .rst(rst), .clr(trk_clr), .smp(trk_smp),
      .pass(pass[b]), .tap(scan_tap), .mid(mid[b]), .fail(fail[b])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        rd_tap_q[b] <= '0;
        wr_tap_q[b] <= '0;
        err_q[b]    <= 1'b0;
      end else begin
        if (err_clr)            err_q[b]    <= 1'b0;
        else if ((commit_rd || commit_wr) && fail[b]) err_q[b] <= 1'b1;
        if (load_rd_scan)       rd_tap_q[b] <= scan_tap;
        else if (commit_rd)     rd_tap_q[b] <= fail[b] ? '0 : mid[b];
        if (load_wr_scan)       wr_tap_q[b] <= scan_tap;
        else if (commit_wr)     wr_tap_q[b] <= fail[b] ? '0 : mid[b];
      end
    end

    assign rd_tap[b*TAP_W +: TAP_W] = rd_tap_q[b];
    assign wr_tap[b*TAP_W +: TAP_W] = wr_tap_q[b];
  end

  assign bit_err = err_q;

  // R10: completion and activity are exclusive
  assert_done_busy_R10: assert property (@(posedge clk) disable iff (rst)
    !(done && busy));

  // R9: error flags only clear on an accepted start
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    !err_clr |=> ((bit_err & $past(bit_err)) == $past(bit_err)));

  // R7: trained read taps stay put through the write sweep
  assert_rd_tap_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (load_wr_scan && $past(load_wr_scan) == 1'b0 && !commit_rd) |=> $stable(rd_tap));

endmodule

// File: tb/eye_center_trainer_bench.sv
`timescale 1ns/1ps
module eye_center_trainer_bench;

  localparam int DQ_W  = 16;
  localparam int TAP_W = 6;
  localparam int BEATS = 8;
  localparam int BUS_W = DQ_W * BEATS;
  localparam int NTAP  = 1 << TAP_W;
  localparam int WDOG  = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic busy, done, mrw_valid, cmd_valid, cmd_wr;
  logic [2:0] mrw_reg;
  logic [15:0] mrw_data;
  logic [BUS_W-1:0] cmd_wdata;
  logic rd_valid = 1'b0;
  logic [BUS_W-1:0] rd_data = '0;
  logic [DQ_W*TAP_W-1:0] rd_tap, wr_tap;
  logic [DQ_W-1:0] bit_err;

  always #2.5 clk = ~clk;

  eye_center_trainer u_eye_center_trainer (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .mrw_valid(mrw_valid), .mrw_reg(mrw_reg), .mrw_data(mrw_data),
    .cmd_valid(cmd_valid), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_tap(rd_tap), .wr_tap(wr_tap), .bit_err(bit_err)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-bit pass windows of the memory model (empty when lo > hi)
  int rlo [DQ_W], rhi [DQ_W], wlo [DQ_W], whi [DQ_W];
  int e_rd [DQ_W], e_wr [DQ_W];
  bit e_err [DQ_W];

  // run bookkeeping (model side)
  bit mpr_mode = 0;
  logic [BUS_W-1:0] mpr_q = '0, arr_q = '0, resp = '0;
  bit pend = 0;
  int dly = 0;
  int mrw_cnt, mpr_wr, mpr_rd, arr_wr, arr_rd, first_cmd_seen;

  function automatic logic [BUS_W-1:0] exp_pat();
    logic [BUS_W-1:0] d;
    for (int k = 0; k < BEATS; k++)
      for (int j = 0; j < DQ_W / 8; j++)
        d[k*DQ_W + 8*j +: 8] = (k % 2 == 0) ? 8'h55 : 8'hAA;
    return d;
  endfunction

  function automatic int tap_of(input logic [DQ_W*TAP_W-1:0] v, input int b);
    return int'(v[b*TAP_W +: TAP_W]);
  endfunction

  function automatic logic [BUS_W-1:0] spoil(input logic [BUS_W-1:0] d,
                                            input logic [DQ_W*TAP_W-1:0] taps,
                                            input bit rd_side);
    logic [BUS_W-1:0] o = d;
    for (int b = 0; b < DQ_W; b++) begin
      int t = tap_of(taps, b);
      int lo = rd_side ? rlo[b] : wlo[b];
      int hi = rd_side ? rhi[b] : whi[b];
      if (t < lo || t > hi)
        for (int k = 0; k < BEATS; k++) o[k*DQ_W + b] = 1'b0;
    end
    return o;
  endfunction

  function automatic bit taps_all(input logic [DQ_W*TAP_W-1:0] v, input int n);
    for (int b = 0; b < DQ_W; b++) if (tap_of(v, b) != n) return 0;
    return 1;
  endfunction

  // behavioural memory: observes strobes mid-cycle, answers reads after a random delay
  always @(negedge clk) begin
    if (rst) begin
      rd_valid = 1'b0;
      pend = 0;
      mpr_mode = 0;
    end else begin
      rd_valid = 1'b0;
      if (pend) begin
        if (dly == 0) begin
          rd_valid = 1'b1;
          rd_data = resp;
          pend = 0;
        end else dly--;
      end
      if (mrw_valid) begin
        mrw_cnt++;
        chk(mrw_reg == 3'd3, "R2 mode register index", int'(mrw_reg), 3);
        if (mrw_cnt == 1)
          chk(mrw_data[2] == 1'b1 && first_cmd_seen == 0, "R2 readback enable first", int'(mrw_data), 4);
        else if (mrw_cnt == 2) begin
          chk(mrw_data[2] == 1'b0, "R5 readback disable", int'(mrw_data), 0);
          chk(mpr_rd == NTAP && arr_wr == 0, "R5 clear after read sweep", mpr_rd, NTAP);
        end
        if (mrw_reg == 3'd3) mpr_mode = mrw_data[2];
      end
      if (cmd_valid) begin
        if (first_cmd_seen == 0)
          chk(cmd_wr && mpr_mode, "R2 first command is pattern load", int'(cmd_wr), 1);
        first_cmd_seen = 1;
        if (cmd_wr) begin
          chk(cmd_wdata == exp_pat(), "R3 write pattern", int'(cmd_wdata[31:0]), int'(exp_pat() & 32'hFFFFFFFF));
          if (mpr_mode) begin
            mpr_wr++;
            mpr_q = cmd_wdata;
          end else begin
            chk(taps_all(wr_tap, arr_wr), "R7 write tap step", tap_of(wr_tap, 0), arr_wr);
            for (int b = 0; b < DQ_W; b++)
              chk(tap_of(rd_tap, b) == e_rd[b], "R7 read tap held", tap_of(rd_tap, b), e_rd[b]);
            arr_wr++;
            arr_q = spoil(cmd_wdata, wr_tap, 0);
          end
        end else begin
          if (mpr_mode) begin
            chk(mpr_wr == 1, "R2 read after pattern load", mpr_wr, 1);
            chk(taps_all(rd_tap, mpr_rd), "R4 read tap step", tap_of(rd_tap, 0), mpr_rd);
            mpr_rd++;
            resp = spoil(mpr_q, rd_tap, 1);
          end else begin
            arr_rd++;
            resp = spoil(arr_q, rd_tap, 1);
          end
          pend = 1;
          dly = $urandom_range(0, 3);
        end
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic set_random(input int empty_pct);
    for (int b = 0; b < DQ_W; b++) begin
      rlo[b] = $urandom_range(0, NTAP - 1);
      rhi[b] = $urandom_range(rlo[b], NTAP - 1);
      wlo[b] = $urandom_range(0, NTAP - 1);
      whi[b] = $urandom_range(wlo[b], NTAP - 1);
      if ($urandom_range(0, 99) < empty_pct) begin rlo[b] = 1; rhi[b] = 0; end
      if ($urandom_range(0, 99) < empty_pct) begin wlo[b] = 1; whi[b] = 0; end
    end
  endtask

  task automatic compute_expect();
    for (int b = 0; b < DQ_W; b++) begin
      bit rok = rlo[b] <= rhi[b];
      bit wok = rok && (wlo[b] <= whi[b]);
      e_rd[b]  = rok ? (rlo[b] + rhi[b]) / 2 : 0;
      e_wr[b]  = wok ? (wlo[b] + whi[b]) / 2 : 0;
      e_err[b] = !wok;
    end
  endtask

  task automatic run_train(input bit poke_mid);
    compute_expect();
    mrw_cnt = 0; mpr_wr = 0; mpr_rd = 0; arr_wr = 0; arr_rd = 0; first_cmd_seen = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    chk(busy && !done, "R10 busy after start", int'(busy), 1);
    chk(bit_err == '0, "R9 flags cleared by start", int'(bit_err), 0);
    if (poke_mid) begin
      repeat (300) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (!done) @(negedge clk);
    chk(!busy, "R10 busy low at done", int'(busy), 0);
    chk(mrw_cnt == 2, "R5 two mode writes", mrw_cnt, 2);
    chk(mpr_wr == 1, "R2 single pattern load", mpr_wr, 1);
    chk(mpr_rd == NTAP, "R4 read sweep length", mpr_rd, NTAP);
    chk(arr_wr == NTAP && arr_rd == NTAP, "R7 write sweep length", arr_wr, NTAP);
    for (int b = 0; b < DQ_W; b++) begin
      chk(tap_of(rd_tap, b) == e_rd[b], "R6 read midpoint", tap_of(rd_tap, b), e_rd[b]);
      chk(tap_of(wr_tap, b) == e_wr[b], "R8 write midpoint", tap_of(wr_tap, b), e_wr[b]);
      chk(bit_err[b] == e_err[b], "R9 error flag", int'(bit_err[b]), int'(e_err[b]));
    end
    if (poke_mid) chk(mrw_cnt == 2 && mpr_wr == 1, "R11 restart ignored", mrw_cnt, 2);
    repeat (5) @(negedge clk);
    chk(done && !busy, "R10 done held", int'(done), 1);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !cmd_valid && !mrw_valid, "R1 idle controls", int'(busy), 0);
    chk(bit_err == '0, "R1 flags", int'(bit_err), 0);
    chk(rd_tap == '0 && wr_tap == '0, "R1 taps", tap_of(rd_tap, 0), 0);

    // directed edge windows on the first bits, random elsewhere
    set_random(0);
    rlo[0] = 0;  rhi[0] = 63; wlo[0] = 0;  whi[0] = 63;
    rlo[1] = 0;  rhi[1] = 0;  wlo[1] = 0;  whi[1] = 0;
    rlo[2] = 63; rhi[2] = 63; wlo[2] = 63; whi[2] = 63;
    rlo[3] = 62; rhi[3] = 63; wlo[3] = 62; whi[3] = 63;
    rlo[4] = 1;  rhi[4] = 0;  wlo[4] = 5;  whi[4] = 9;
    rlo[5] = 10; rhi[5] = 20; wlo[5] = 1;  whi[5] = 0;
    run_train(0);

    set_random(0);
    run_train(0);
    for (int r = 0; r < 4; r++) begin
      set_random(15);
      run_train(r == 1);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule